// File: doc/BRIEF.md
# Page Write Cache and Commit Sequencer

This block sits between a serial-memory bus controller and a page-organised memory array. It holds write data in a 64-byte cache arranged as eight lines of eight bytes. When a write command opens, the controller hands over a start address. The controller then delivers the write bytes one at a time, and a STOP strobe closes the command. The first byte always lands in cache line 0, at the lane selected by the low three address bits. Later bytes fill upward through the lines. Once 64 positions have been passed, the pointer wraps to line 0, lane 0, and overwrites what was there.

On STOP the sequencer visits the cache lines in order. For each line that holds at least one loaded byte, it issues one page write to the array. Cache line k goes to array page (start page + k), and the page number wraps modulo the array size. The page write carries a byte-enable for every loaded lane and for no other lane. Each page write then occupies a fixed, parameterised number of clock ticks. A line with nothing loaded costs one clock and produces no write. A busy flag covers the whole commit. While it is high, the block takes no commands and suppresses the controller's acknowledge.

Top module: `pgcache_commit`

## Requirements
- R1: After reset, `busy_o` and `arr_we` are low, and no byte of the cache counts as loaded.
- R2: The first byte of a command is stored at cache line 0, lane `cmd_addr[2:0]`. On commit it is written to array page `cmd_addr >> 3`, at that same lane. A byte presented in the same cycle as `cmd_start` is that first byte.
- R3: Each accepted byte advances a 6-bit cache pointer by one. When the lane field passes 7, the next byte goes to lane 0 of the following cache line, and so to the following array page.
- R4: After 64 pointer positions the pointer wraps to line 0, lane 0, and the newest byte at a position replaces the older one. With a nonzero start lane, the wrapped bytes fill the lanes of line 0 below the start lane.
- R5: No page write occurs before STOP. After STOP, cache line k is written to array page (start page + k) modulo the number of array pages. Busy never rises without a STOP in the previous cycle.
- R6: The byte enables of a page write (`arr_be` bit b = lane b) are set exactly for the lanes loaded since the command began. Lanes that were not loaded keep their array contents.
- R7: A loaded line takes one cycle with `arr_we` high, followed by `PAGE_TICKS-1` quiet cycles. A line with no loaded byte is passed over in one clock with no write. With n loaded lines, `busy_o` stays high for n*PAGE_TICKS + (8-n) cycles.
- R8: `busy_o` rises in the cycle after an accepted STOP. While it is high, `cmd_start`, `byte_valid` and `stop_strobe` have no effect.
- R9: `ack_o` follows `ack_req` while idle, and is held low whenever `busy_o` is high.
- R10: All loaded marks are cleared when busy falls. A STOP with no new bytes afterwards produces no page write.
- R11: A byte and STOP in the same cycle are both taken: the byte is stored and is part of the commit that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Opens a write command at `cmd_addr` |
| cmd_addr | input | ADDR_W | Start byte address of the command |
| byte_valid | input | 1 | A write byte is presented |
| byte_data | input | BYTE_W | Write byte |
| stop_strobe | input | 1 | STOP seen; start committing |
| ack_req | input | 1 | Controller wishes to acknowledge |
| busy_o | output | 1 | Commit in progress |
| ack_o | output | 1 | Gated acknowledge |
| arr_we | output | 1 | Array page write pulse |
| arr_page | output | ADDR_W-3 | Array page number |
| arr_data | output | PAGE_BYTES*BYTE_W | Page data, lane b at bits [8b+7:8b] |
| arr_be | output | PAGE_BYTES | Per-lane write enables |

## Verification
Two events can fall in the same cycle. The last byte of a command may arrive together with STOP, and the first byte may arrive together with the start strobe. The sweep provokes the first case on every odd trial and the second on every trial. The result is judged by the final array contents, the write-pulse count and the busy length, which all come from an arithmetic model of the cache pointer. A third overlap is also provoked: fresh commands, bytes and STOPs are driven during a commit. The bench checks that the page writes and the busy length are those of the command already stored.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SCAN = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pgc_cache_store.sv
module pgc_cache_store #(
  parameter int BYTE_W      = 8,
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int LINE_W = $clog2(CACHE_PAGES),
  localparam int PTR_W  = OFF_W + LINE_W,
  localparam int DEPTH  = PAGE_BYTES * CACHE_PAGES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         restart,
  input  logic [OFF_W-1:0]             start_off,
  input  logic                         push,
  input  logic [BYTE_W-1:0]            push_data,
  input  logic                         clear_all,
  input  logic [LINE_W-1:0]            rd_line,
  output logic [PAGE_BYTES*BYTE_W-1:0] rd_data,
  output logic [PAGE_BYTES-1:0]        rd_be
);

  logic [PTR_W-1:0]  ptr_q, ptr_d, ptr_base;
  logic [DEPTH-1:0]  valid_q, valid_d;
  logic [BYTE_W-1:0] mem_q [DEPTH];

  // a restart rebases the pointer in the same cycle, so a byte
  // arriving with the start strobe lands at the start lane
  always_comb begin
    ptr_base = restart ? {{LINE_W{1'b0}}, start_off} : ptr_q;
    ptr_d    = push ? ptr_base + PTR_W'(1) : ptr_base;
  end

  always_comb begin
    valid_d = valid_q;
    if (clear_all || restart) valid_d = '0;
    if (push) valid_d[ptr_base] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      valid_q <= '0;
    end else begin
      if (restart || push) ptr_q <= ptr_d;
      if (restart || push || clear_all) valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[ptr_base] <= push_data;
  end

  generate
    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_lane
      localparam logic [OFF_W-1:0] LANE = OFF_W'(b);
      assign rd_data[b*BYTE_W +: BYTE_W] = mem_q[{rd_line, LANE}];
      assign rd_be[b] = valid_q[{rd_line, LANE}];
    end
  endgenerate

endmodule

// File: rtl/pgc_tick_timer.sv
module pgc_tick_timer #(
  parameter int PAGE_TICKS = 1000,
  localparam int CNT_W = (PAGE_TICKS > 2) ? $clog2(PAGE_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // loaded in the write-pulse cycle; expires after PAGE_TICKS-1 run cycles
  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = CNT_W'(PAGE_TICKS - 2);
    else if (run && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load || run) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pgc_commit_seq.sv
module pgc_commit_seq
  import pgc_pkg::*;
#(
  parameter int CACHE_PAGES = 8,
  parameter int PAGE_BYTES  = 8,
  parameter int PAGE_AW     = 9,
  localparam int LINE_W = $clog2(CACHE_PAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [PAGE_AW-1:0]    base_page,
  input  logic [PAGE_BYTES-1:0] line_be,
  input  logic                  tmr_expired,
  output logic                  busy,
  output logic [LINE_W-1:0]     line_idx,
  output logic                  wr_en,
  output logic [PAGE_AW-1:0]    wr_page,
  output logic                  tmr_load,
  output logic                  tmr_run,
  output logic                  clear_valid
);

  localparam logic [LINE_W-1:0] LAST = LINE_W'(CACHE_PAGES - 1);

  seq_state_t        st_q, st_d;
  logic [LINE_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    wr_en       = 1'b0;
    tmr_load    = 1'b0;
    clear_valid = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (go) begin
          st_d  = SEQ_SCAN;
          idx_d = '0;
        end
      end
      SEQ_SCAN: begin
        if (|line_be) begin
          wr_en    = 1'b1;
          tmr_load = 1'b1;
          st_d     = SEQ_WAIT;
        end else if (idx_q == LAST) begin
          st_d        = SEQ_IDLE;
          clear_valid = 1'b1;
        end else begin
          idx_d = idx_q + LINE_W'(1);
        end
      end
      SEQ_WAIT: begin
        if (tmr_expired) begin
          if (idx_q == LAST) begin
            st_d        = SEQ_IDLE;
            clear_valid = 1'b1;
          end else begin
            st_d  = SEQ_SCAN;
            idx_d = idx_q + LINE_W'(1);
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign busy     = (st_q != SEQ_IDLE);
  assign tmr_run  = (st_q == SEQ_WAIT);
  assign line_idx = idx_q;
  assign wr_page  = base_page + PAGE_AW'(idx_q);

endmodule

// File: rtl/pgcache_commit.sv
module pgcache_commit #(
  parameter int BYTE_W      = 8,
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8,
  parameter int ADDR_W      = 12,
  parameter int PAGE_TICKS  = 1000,
  localparam int OFF_W   = $clog2(PAGE_BYTES),
  localparam int LINE_W  = $clog2(CACHE_PAGES),
  localparam int PAGE_AW = ADDR_W - OFF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_start,
  input  logic [ADDR_W-1:0]            cmd_addr,
  input  logic                         byte_valid,
  input  logic [BYTE_W-1:0]            byte_data,
  input  logic                         stop_strobe,
  input  logic                         ack_req,
  output logic                         busy_o,
  output logic                         ack_o,
  output logic                         arr_we,
  output logic [PAGE_AW-1:0]           arr_page,
  output logic [PAGE_BYTES*BYTE_W-1:0] arr_data,
  output logic [PAGE_BYTES-1:0]        arr_be
);

  logic               start_ok, push_ok, go_ok;
  logic [PAGE_AW-1:0] base_page_q;
  logic [LINE_W-1:0]  line_idx;
  logic               tmr_load, tmr_run, tmr_expired, clear_valid;

  // every command input is refused while a commit runs
  assign start_ok = cmd_start   & ~busy_o;
  assign push_ok  = byte_valid  & ~busy_o;
  assign go_ok    = stop_strobe & ~busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_page_q <= '0;
    else if (start_ok) base_page_q <= cmd_addr[ADDR_W-1:OFF_W];
  end

  pgc_cache_store #(
    .BYTE_W     (BYTE_W),
    .PAGE_BYTES (PAGE_BYTES),
    .CACHE_PAGES(CACHE_PAGES)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start_ok),
    .start_off(cmd_addr[OFF_W-1:0]),
    .push     (push_ok),
    .push_data(byte_data),
    .clear_all(clear_valid),
    .rd_line  (line_idx),
    .rd_data  (arr_data),
    .rd_be    (arr_be)
  );

  pgc_commit_seq #(
    .CACHE_PAGES(CACHE_PAGES),
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_AW    (PAGE_AW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go_ok),
    .base_page  (base_page_q),
    .line_be    (arr_be),
    .tmr_expired(tmr_expired),
    .busy       (busy_o),
    .line_idx   (line_idx),
    .wr_en      (arr_we),
    .wr_page    (arr_page),
    .tmr_load   (tmr_load),
    .tmr_run    (tmr_run),
    .clear_valid(clear_valid)
  );

  pgc_tick_timer #(
    .PAGE_TICKS(PAGE_TICKS)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .run    (tmr_run),
    .expired(tmr_expired)
  );

  assign ack_o = ack_req & ~busy_o;

endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
  parameter int PAGE_BYTES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy_o,
  input logic                  ack_o,
  input logic                  stop_strobe,
  input logic                  arr_we,
  input logic [PAGE_BYTES-1:0] arr_be
);

  assert_we_inside_busy_R8: assert property (
    @(posedge clk) disable iff (!rst_n) arr_we |-> busy_o);

  assert_ack_held_low_R9: assert property (
    @(posedge clk) disable iff (!rst_n) busy_o |-> !ack_o);

  assert_we_spaced_R7: assert property (
    @(posedge clk) disable iff (!rst_n) arr_we |=> !arr_we);

  assert_be_not_empty_R6: assert property (
    @(posedge clk) disable iff (!rst_n) arr_we |-> (arr_be != '0));

  assert_busy_after_stop_R5: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(stop_strobe));

endmodule

bind pgcache_commit pgc_checker #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .ack_o      (ack_o),
  .stop_strobe(stop_strobe),
  .arr_we     (arr_we),
  .arr_be     (arr_be)
);

// File: tb/sim_pgcache_commit.sv
`timescale 1ns/1ps
module sim_pgcache_commit;
  localparam int AW    = 8;
  localparam int TICKS = 4;
  localparam int NPG   = 1 << (AW - 3);
  localparam int MEMSZ = 1 << AW;

  logic            clk, rst_n;
  logic            cmd_start, byte_valid, stop_strobe, ack_req;
  logic [AW-1:0]   cmd_addr;
  logic [7:0]      byte_data;
  logic            busy_o, ack_o, arr_we;
  logic [AW-4:0]   arr_page;
  logic [63:0]     arr_data;
  logic [7:0]      arr_be;

  int checks = 0, failures = 0;
  int pulses = 0, busy_cnt = 0;
  logic [7:0] ram [MEMSZ];
  logic [7:0] expm [MEMSZ];

  pgcache_commit #(.ADDR_W(AW), .PAGE_TICKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_strobe(stop_strobe),
    .ack_req(ack_req), .busy_o(busy_o), .ack_o(ack_o), .arr_we(arr_we),
    .arr_page(arr_page), .arr_data(arr_data), .arr_be(arr_be));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // array model, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      pulses++;
      for (int b = 0; b < 8; b++)
        if (arr_be[b]) ram[int'(arr_page)*8 + b] = arr_data[b*8 +: 8];
    end
    if (rst_n && busy_o) busy_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input int s, input int i);
    return 8'(s * 37 + i * 11 + 5);
  endfunction

  task automatic compare_mem(input string req);
    int bad = -1;
    for (int a = 0; a < MEMSZ; a++)
      if (bad < 0 && ram[a] !== expm[a]) bad = a;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, {req, " mem byte mismatch"}, int'(ram[bad]), int'(expm[bad]));
  endtask

  // arithmetic model of one command: returns loaded line count
  function automatic int model(input int addr, input int n, input int seed);
    logic [7:0] cval [64];
    bit cv [64];
    bit lv [8];
    int nv = 0;
    int off = addr % 8;
    int sp = addr / 8;
    for (int p = 0; p < 64; p++) cv[p] = 1'b0;
    for (int l = 0; l < 8; l++) lv[l] = 1'b0;
    for (int i = 0; i < n; i++) begin
      cval[(off + i) % 64] = dat(seed, i);
      cv[(off + i) % 64] = 1'b1;
    end
    for (int p = 0; p < 64; p++)
      if (cv[p]) begin
        expm[((sp + p / 8) % NPG) * 8 + p % 8] = cval[p];
        lv[p / 8] = 1'b1;
      end
    for (int l = 0; l < 8; l++) if (lv[l]) nv++;
    return nv;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    #1;
  endtask

  task automatic run_tx(input int addr, input int n, input int seed, input bit stop_last);
    int nv;
    pulses = 0;
    busy_cnt = 0;
    @(posedge clk); #2;
    cmd_start = 1'b1; cmd_addr = AW'(addr);      // R2 first byte with start
    byte_valid = 1'b1; byte_data = dat(seed, 0);
    stop_strobe = (n == 1) && stop_last;
    for (int i = 1; i < n; i++) begin
      @(posedge clk); #2;
      cmd_start = 1'b0; byte_data = dat(seed, i);
      stop_strobe = (i == n - 1) && stop_last;   // R11 byte with STOP
    end
    @(posedge clk); #2;
    cmd_start = 1'b0; byte_valid = 1'b0;
    if (!stop_last) begin
      stop_strobe = 1'b1;
      @(posedge clk); #2;
    end
    stop_strobe = 1'b0;
    check(pulses == 0, "R5 no write before STOP", pulses, 0);
    wait_idle();
    nv = model(addr, n, seed);
    if (stop_last) compare_mem("R11 R2 R3 R4 R6 array contents");
    else compare_mem("R2 R3 R4 R6 array contents");
    check(pulses == nv, "R7 page write count", pulses, nv);
    check(busy_cnt == nv * TICKS + (8 - nv), "R7 busy length", busy_cnt, nv * TICKS + (8 - nv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int trial = 0;
    int counts [7] = '{1, 5, 8, 9, 20, 64, 67};
    for (int a = 0; a < MEMSZ; a++) begin ram[a] = 8'h00; expm[a] = 8'h00; end
    rst_n = 1'b0; cmd_start = 1'b0; cmd_addr = '0; byte_valid = 1'b0;
    byte_data = '0; stop_strobe = 1'b0; ack_req = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    check(arr_we == 1'b0, "R1 write idle after reset", arr_we, 0);
    ack_req = 1'b1; #1;
    check(ack_o == 1'b1, "R9 ack passes while idle", ack_o, 1);
    ack_req = 1'b0;
    // R10 from reset: nothing loaded, nothing written
    pulses = 0; busy_cnt = 0;
    @(posedge clk); #2 stop_strobe = 1'b1;
    @(posedge clk); #2 stop_strobe = 1'b0;
    wait_idle();
    check(pulses == 0, "R1 R10 empty commit writes nothing", pulses, 0);
    check(busy_cnt == 8, "R7 empty commit length", busy_cnt, 8);

    // sweep: every start lane, several lengths, start pages near the top
    for (int off = 0; off < 8; off++)
      for (int c = 0; c < 7; c++) begin
        run_tx(((trial * 7 + 29) % NPG) * 8 + off, counts[c], trial, trial[0]);
        trial++;
      end

    // R8 and R9: stimulus during a commit is ignored, ack held low
    pulses = 0; busy_cnt = 0;
    @(posedge clk); #2;
    cmd_start = 1'b1; cmd_addr = 8'h40; byte_valid = 1'b1; byte_data = dat(200, 0);
    @(posedge clk); #2; cmd_start = 1'b0; byte_data = dat(200, 1);
    @(posedge clk); #2; byte_data = dat(200, 2);
    @(posedge clk); #2; byte_valid = 1'b0; stop_strobe = 1'b1;
    @(posedge clk); #2;
    cmd_start = 1'b1; cmd_addr = 8'h10; byte_valid = 1'b1; byte_data = 8'hEE;
    stop_strobe = 1'b1; ack_req = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b1, "R8 busy after STOP", busy_o, 1);
    check(ack_o == 1'b0, "R9 ack held low while busy", ack_o, 0);
    repeat (5) @(posedge clk);
    #2 cmd_start = 1'b0; byte_valid = 1'b0; stop_strobe = 1'b0; ack_req = 1'b0;
    wait_idle();
    void'(model(8'h40, 3, 200));
    compare_mem("R8 inputs ignored while busy");
    check(pulses == 1, "R8 write count with ignored input", pulses, 1);
    check(busy_cnt == TICKS + 7, "R8 busy length with ignored input", busy_cnt, TICKS + 7);

    // R10: loaded marks gone after a commit
    pulses = 0; busy_cnt = 0;
    @(posedge clk); #2 stop_strobe = 1'b1;
    @(posedge clk); #2 stop_strobe = 1'b0;
    wait_idle();
    check(pulses == 0, "R10 repeat STOP writes nothing", pulses, 0);
    compare_mem("R10 array unchanged");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule